// File: doc/BRIEF.md
# Dual Maskable Calendar Alarm Unit

This block watches a running calendar (second, minute, hour, day of week, date, month) and raises alarms when it reaches a programmed pattern. There are two alarm channels, and they work independently. Each channel has a six-field pattern and a six-bit field-enable mask. Only the enabled fields are compared. Partial patterns therefore work: every minute, every Tuesday, or one exact moment in the year. Comparison happens once per one-second tick. An alarm fires on the tick where its pattern starts to match. A match that is held over later ticks does not fire again.

When a channel fires, it sets a sticky status flag that software can poll. The flag stays set until a clear strobe clears it. A channel in single-shot mode disarms itself when it fires and must be armed again. A channel in repeat mode stays armed, so it produces periodic events. The pattern registers are stored outside this block and arrive as plain inputs.

Both channels share one active-low pin. A mode select decides what the pin carries:
- the interrupt, which is driven when a flag is set and its interrupt enable is on;
- one of three square waves divided down from the oscillator: 1 Hz, 4096 Hz or 32768 Hz.

The pin is inactive in interrupt mode when no enabled flag is set.

Top module: `dual_alarm_unit`

## Requirements
- R1: After reset, all flags read 0, `pin_n` is 1 and both channels are disarmed: a matching tick sets no flag until that channel has been armed through `alm_arm`.
- R2: On a cycle with `sec_tick` high, an armed channel fires when every enabled field of `cal_now` equals the same field of its pattern. Fields are 8-bit slices ordered from bit 0: second, minute, hour, day of week, date, month. Enable bit k gates field k. Disabled fields are ignored. The flag is visible the cycle after the tick.
- R3: A channel whose six enable bits are all zero never fires.
- R4: A channel fires only when the match rises. If the previous evaluated tick also matched, it does not fire again. An arm strobe clears this match history.
- R5: With its repeat bit at 0, a channel disarms itself when it fires and ignores later matches until an `alm_arm` strobe.
- R6: With its repeat bit at 1, a channel stays armed and fires again on each new rising match.
- R7: A flag stays set until a `stat_clr` strobe with its bit at 1. A clear leaves the other channel's flag alone. A fire in the same cycle as a clear leaves the flag set.
- R8: The calendar and pattern inputs have no effect on cycles without `sec_tick`.
- R9: With `pin_sel` = 00 (interrupt mode), `pin_n` is 0 exactly when some flag is set and its `alm_ien` bit is 1. `pin_n` follows one cycle after the flag.
- R10: With `pin_sel` = 11, 10 or 01, `pin_n` carries a square wave of 32768 Hz, 4096 Hz or 1 Hz. An internal counter advances on each `osc_en` pulse (the pulses come at twice 32768 Hz). `pin_n` shows bit 0, bit 3 or bit 15 of that counter, one cycle after the counter changes.
- R11: The two channels are independent. Each has its own pattern, enables, repeat bit, arm strobe and flag, and they share only the output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second; the calendar value is evaluated on this cycle |
| cal_now | input | 48 | Current calendar, six 8-bit fields |
| alm_pat | input | 96 | Alarm patterns; channel 0 in bits 47:0, channel 1 in bits 95:48 |
| alm_fen | input | 12 | Field enables; channel 0 in bits 5:0, channel 1 in bits 11:6 |
| alm_rpt | input | 2 | Repeat mode per channel |
| alm_arm | input | 2 | Arm strobe per channel |
| alm_ien | input | 2 | Interrupt enable per channel |
| stat_clr | input | 2 | Flag clear strobe per channel |
| osc_en | input | 1 | Oscillator pulse at twice 32768 Hz |
| pin_sel | input | 2 | Pin mode: 00 interrupt, 01 1 Hz, 10 4096 Hz, 11 32768 Hz |
| alm_flag | output | 2 | Sticky alarm flags |
| pin_n | output | 1 | Shared active-low interrupt or clock output |

## Verification
The hardest situation to reach from the ports is a single-shot channel whose pattern matches again after it has already fired. The rising-edge history must be broken first, by a non-matching tick. Only then can the disarm itself be told apart from edge suppression. Directed steps go to that state: fire, move the calendar off the pattern, return to it, then re-arm and return once more. Seeded random ticks use very narrow field ranges so that partial matches, held matches and clears that coincide with fires happen often. A bench model predicts every flag and the pin after each step.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
  localparam int unsigned FLD_W   = 8;
  localparam int unsigned N_FLD   = 6;
  localparam int unsigned N_ALM   = 2;
  localparam int unsigned OSC_HZ  = 32768;
  localparam int unsigned F_MID   = 4096;

  typedef enum logic [1:0] {
    PIN_IRQ  = 2'b00,
    PIN_SLOW = 2'b01,
    PIN_MID  = 2'b10,
    PIN_FAST = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned FLD_W = 8,
  parameter int unsigned N_FLD = 6,
  localparam int unsigned CAL_W = FLD_W * N_FLD
) (
  input  logic [CAL_W-1:0] now_i,
  input  logic [CAL_W-1:0] pat_i,
  input  logic [N_FLD-1:0] fen_i,
  output logic             hit_o
);
  logic [N_FLD-1:0] fld_ok;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    assign fld_ok[f] = !fen_i[f] ||
                       (now_i[f*FLD_W +: FLD_W] == pat_i[f*FLD_W +: FLD_W]);
  end

  // an empty mask never matches
  assign hit_o = (&fld_ok) && (|fen_i);
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int unsigned FLD_W = 8,
  parameter int unsigned N_FLD = 6,
  localparam int unsigned CAL_W = FLD_W * N_FLD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] now_i,
  input  logic [CAL_W-1:0] pat_i,
  input  logic [N_FLD-1:0] fen_i,
  input  logic             rpt_i,
  input  logic             arm_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic hit;
  logic armed_q, armed_d;
  logic mhist_q, mhist_d;
  logic flag_q, flag_d;
  logic fire;

  alarm_field_cmp #(.FLD_W(FLD_W), .N_FLD(N_FLD)) u_cmp (
    .now_i (now_i),
    .pat_i (pat_i),
    .fen_i (fen_i),
    .hit_o (hit)
  );

  always_comb begin
    fire = tick_i && hit && !mhist_q && armed_q;

    mhist_d = mhist_q;
    if (arm_i)       mhist_d = 1'b0;
    else if (tick_i) mhist_d = hit;

    armed_d = armed_q;
    if (arm_i)              armed_d = 1'b1;
    else if (fire && !rpt_i) armed_d = 1'b0;

    flag_d = flag_q;
    if (fire)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mhist_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      mhist_q <= mhist_d;
      flag_q  <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux
  import alarm_unit_pkg::*;
#(
  parameter int unsigned OSC_HZ = 32768,
  parameter int unsigned F_MID  = 4096,
  localparam int unsigned DIV_W    = $clog2(OSC_HZ) + 1,
  localparam int unsigned IDX_SLOW = $clog2(OSC_HZ),
  localparam int unsigned IDX_MID  = $clog2(OSC_HZ / F_MID),
  localparam int unsigned IDX_FAST = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en_i,
  input  logic [1:0] sel_i,
  input  logic       irq_req_i,
  output logic       pin_n_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             pin_q, pin_d;

  always_comb begin
    div_d = div_q;
    if (osc_en_i) div_d = div_q + 1'b1;

    unique case (sel_i)
      PIN_SLOW: pin_d = div_q[IDX_SLOW];
      PIN_MID:  pin_d = div_q[IDX_MID];
      PIN_FAST: pin_d = div_q[IDX_FAST];
      default:  pin_d = !irq_req_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pin_q <= 1'b1;
    end else begin
      div_q <= div_d;
      pin_q <= pin_d;
    end
  end

  assign pin_n_o = pin_q;
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import alarm_unit_pkg::*;
#(
  parameter int unsigned N_ALM  = alarm_unit_pkg::N_ALM,
  parameter int unsigned FLD_W  = alarm_unit_pkg::FLD_W,
  parameter int unsigned N_FLD  = alarm_unit_pkg::N_FLD,
  parameter int unsigned OSC_HZ = alarm_unit_pkg::OSC_HZ,
  parameter int unsigned F_MID  = alarm_unit_pkg::F_MID,
  localparam int unsigned CAL_W = FLD_W * N_FLD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sec_tick,
  input  logic [CAL_W-1:0]         cal_now,
  input  logic [N_ALM*CAL_W-1:0]   alm_pat,
  input  logic [N_ALM*N_FLD-1:0]   alm_fen,
  input  logic [N_ALM-1:0]         alm_rpt,
  input  logic [N_ALM-1:0]         alm_arm,
  input  logic [N_ALM-1:0]         alm_ien,
  input  logic [N_ALM-1:0]         stat_clr,
  input  logic                     osc_en,
  input  logic [1:0]               pin_sel,
  output logic [N_ALM-1:0]         alm_flag,
  output logic                     pin_n
);
  logic irq_req;

  for (genvar a = 0; a < N_ALM; a++) begin : g_alm
    alarm_channel #(.FLD_W(FLD_W), .N_FLD(N_FLD)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (sec_tick),
      .now_i  (cal_now),
      .pat_i  (alm_pat[a*CAL_W +: CAL_W]),
      .fen_i  (alm_fen[a*N_FLD +: N_FLD]),
      .rpt_i  (alm_rpt[a]),
      .arm_i  (alm_arm[a]),
      .clr_i  (stat_clr[a]),
      .flag_o (alm_flag[a])
    );
  end

  assign irq_req = |(alm_flag & alm_ien);

  alarm_pin_mux #(.OSC_HZ(OSC_HZ), .F_MID(F_MID)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en_i  (osc_en),
    .sel_i     (pin_sel),
    .irq_req_i (irq_req),
    .pin_n_o   (pin_n)
  );
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk #(
  parameter int unsigned N_ALM = 2,
  parameter int unsigned N_FLD = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sec_tick,
  input logic [N_ALM*N_FLD-1:0] alm_fen,
  input logic [N_ALM-1:0]       alm_arm,
  input logic [N_ALM-1:0]       alm_ien,
  input logic [N_ALM-1:0]       stat_clr,
  input logic [1:0]             pin_sel,
  input logic [N_ALM-1:0]       alm_flag,
  input logic                   pin_n
);
  // R8: flags can only be set in the cycle after a tick
  assert_set_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ((alm_flag & ~$past(alm_flag)) == '0));

  // R7: flags fall only on a clear strobe
  assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr == '0) |=> ((~alm_flag & $past(alm_flag)) == '0));

  // R9: interrupt mode pin tracks enabled flags one cycle later
  assert_irq_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 2'b00) |=> (pin_n == !(|($past(alm_flag & alm_ien)))));

  for (genvar a = 0; a < N_ALM; a++) begin : g_a
    // R3: empty mask never raises the flag
    assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && alm_fen[a*N_FLD +: N_FLD] == '0 && !alm_flag[a])
        |=> !alm_flag[a]);
  end
endmodule

bind dual_alarm_unit alarm_unit_chk #(.N_ALM(N_ALM), .N_FLD(N_FLD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .alm_fen  (alm_fen),
  .alm_arm  (alm_arm),
  .alm_ien  (alm_ien),
  .stat_clr (stat_clr),
  .pin_sel  (pin_sel),
  .alm_flag (alm_flag),
  .pin_n    (pin_n)
);

// File: tb/sim_dual_alarm_unit.sv
`timescale 1ns/1ps
module sim_dual_alarm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick;
  logic [47:0] cal_now;
  logic [95:0] alm_pat;
  logic [11:0] alm_fen;
  logic [1:0]  alm_rpt, alm_arm, alm_ien, stat_clr;
  logic        osc_en;
  logic [1:0]  pin_sel;
  logic [1:0]  alm_flag;
  logic        pin_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit m_armed[2];
  bit m_hist[2];
  bit m_flag[2];
  int oc = 0;

  always #5 clk = ~clk;

  dual_alarm_unit u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_now(cal_now),
    .alm_pat(alm_pat), .alm_fen(alm_fen), .alm_rpt(alm_rpt), .alm_arm(alm_arm),
    .alm_ien(alm_ien), .stat_clr(stat_clr), .osc_en(osc_en), .pin_sel(pin_sel),
    .alm_flag(alm_flag), .pin_n(pin_n)
  );

  function automatic logic [47:0] cal(input int s, input int mi, input int h,
                                      input int dw, input int dt, input int mo);
    return {mo[7:0], dt[7:0], dw[7:0], h[7:0], mi[7:0], s[7:0]};
  endfunction

  function automatic bit model_hit(input int a);
    logic [5:0] fen;
    bit ok;
    fen = alm_fen[a*6 +: 6];
    ok = (fen != 0);
    for (int f = 0; f < 6; f++)
      if (fen[f] && cal_now[f*8 +: 8] != alm_pat[a*48 + f*8 +: 8]) ok = 0;
    return ok;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit tk, input logic [1:0] clr,
                      input logic [1:0] arm);
    bit hit, fire;
    logic exp_pin;
    @(negedge clk);
    sec_tick = tk; stat_clr = clr; alm_arm = arm;
    for (int a = 0; a < 2; a++) begin
      hit  = model_hit(a);
      fire = tk && hit && !m_hist[a] && m_armed[a];
      if (arm[a]) m_hist[a] = 0; else if (tk) m_hist[a] = hit;
      if (arm[a]) m_armed[a] = 1; else if (fire && !alm_rpt[a]) m_armed[a] = 0;
      if (fire) m_flag[a] = 1; else if (clr[a]) m_flag[a] = 0;
    end
    @(negedge clk);
    sec_tick = 0; stat_clr = 0; alm_arm = 0;
    @(negedge clk);
    check({tag, " flags"}, {30'd0, alm_flag}, {30'd0, m_flag[1], m_flag[0]});
    exp_pin = !((m_flag[0] && alm_ien[0]) || (m_flag[1] && alm_ien[1]));
    if (pin_sel == 2'b00) check({tag, " R9 pin"}, {31'd0, pin_n}, {31'd0, exp_pin});
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    osc_en = 1;
    repeat (n) @(negedge clk);
    osc_en = 0;
    oc += n;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; sec_tick = 0; cal_now = '0; alm_pat = '0; alm_fen = '0;
    alm_rpt = 0; alm_arm = 0; alm_ien = 0; stat_clr = 0; osc_en = 0; pin_sel = 0;
    for (int a = 0; a < 2; a++) begin m_armed[a] = 0; m_hist[a] = 0; m_flag[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flags", {30'd0, alm_flag}, 32'd0);
    check("R1 reset pin", {31'd0, pin_n}, 32'd1);

    // R1: matching tick before arming sets nothing
    alm_ien = 2'b11;
    alm_pat[47:0] = cal(0, 5, 0, 0, 0, 0);
    alm_fen[5:0] = 6'b000010;
    cal_now = cal(0, 5, 1, 2, 3, 4);
    step("R1 disarmed", 1, 0, 0);

    // R2/R3: minute-only pattern, empty mask on channel 1
    alm_pat[95:48] = cal(0, 5, 1, 2, 3, 4);
    alm_fen[11:6] = 6'b000000;
    step("R2 arm", 0, 0, 2'b11);
    cal_now = cal(7, 5, 9, 1, 1, 1);
    step("R2 R3 minute match", 1, 0, 0);
    check("R2 fired", {31'd0, alm_flag[0]}, 32'd1);
    check("R3 empty mask", {31'd0, alm_flag[1]}, 32'd0);

    // R4: held match does not retrigger
    step("R7 clear", 0, 2'b01, 0);
    cal_now = cal(8, 5, 9, 1, 1, 1);
    step("R4 held", 1, 0, 0);
    check("R4 no retrigger", {31'd0, alm_flag[0]}, 32'd0);

    // R8: calendar change without tick
    alm_rpt = 2'b01;
    step("R4 arm", 0, 0, 2'b01);
    cal_now = cal(0, 5, 0, 0, 0, 0);
    step("R8 no tick", 0, 0, 0);
    check("R8 no tick no flag", {31'd0, alm_flag[0]}, 32'd0);
    step("R4 after arm fires", 1, 0, 0);
    check("R4 arm clears history", {31'd0, alm_flag[0]}, 32'd1);

    // R5: single shot disarms
    alm_rpt = 2'b00;
    step("R5 clr", 0, 2'b01, 2'b01);
    step("R5 fire", 1, 0, 0);
    step("R5 clr2", 0, 2'b01, 0);
    cal_now = cal(0, 6, 0, 0, 0, 0);
    step("R5 off", 1, 0, 0);
    cal_now = cal(0, 5, 0, 0, 0, 0);
    step("R5 back", 1, 0, 0);
    check("R5 disarmed", {31'd0, alm_flag[0]}, 32'd0);

    // R6: repeat on day-of-week for channel 1
    alm_rpt = 2'b10;
    alm_pat[95:48] = cal(0, 0, 0, 2, 0, 0);
    alm_fen[11:6] = 6'b001000;
    cal_now = cal(0, 0, 0, 2, 9, 9);
    step("R6 arm", 0, 0, 2'b10);
    step("R6 fire1", 1, 0, 0);
    step("R6 clr", 0, 2'b10, 0);
    cal_now = cal(0, 0, 0, 3, 9, 9);
    step("R6 off", 1, 0, 0);
    cal_now = cal(0, 0, 0, 2, 9, 9);
    step("R6 fire2", 1, 0, 0);
    check("R6 refire", {31'd0, alm_flag[1]}, 32'd1);

    // R7: set wins over clear, clear of other channel
    cal_now = cal(0, 0, 0, 3, 9, 9);
    step("R7 off", 1, 2'b10, 0);
    cal_now = cal(0, 0, 0, 2, 9, 9);
    step("R7 set wins", 1, 2'b10, 0);
    check("R7 set over clear", {31'd0, alm_flag[1]}, 32'd1);

    // R9: interrupt enable masking
    alm_ien = 2'b01;
    step("R9 masked", 0, 0, 0);
    check("R9 masked pin high", {31'd0, pin_n}, 32'd1);
    alm_ien = 2'b10;
    step("R9 enabled", 0, 0, 0);

    // R11: random exercise of both channels
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) begin
        for (int f = 0; f < 12; f++) alm_pat[f*8 +: 8] = 8'($urandom % 2);
        alm_fen = 12'($urandom);
        alm_rpt = 2'($urandom);
        alm_ien = 2'($urandom);
      end
      for (int f = 0; f < 6; f++) cal_now[f*8 +: 8] = 8'($urandom % 2);
      step("R11 random", 1'($urandom), ($urandom % 4 == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 8 == 0) ? 2'($urandom) : 2'b00);
    end

    // R10: frequency outputs
    pin_sel = 2'b11;
    pulses(1);
    check("R10 fast bit0", {31'd0, pin_n}, {31'd0, 1'(oc & 1)});
    pulses(1);
    check("R10 fast bit0", {31'd0, pin_n}, {31'd0, 1'(oc & 1)});
    pin_sel = 2'b10;
    pulses(6);
    check("R10 mid bit3", {31'd0, pin_n}, {31'd0, 1'((oc >> 3) & 1)});
    pulses(8);
    check("R10 mid bit3", {31'd0, pin_n}, {31'd0, 1'((oc >> 3) & 1)});
    pin_sel = 2'b01;
    pulses(32767 - oc);
    check("R10 slow bit15 low", {31'd0, pin_n}, {31'd0, 1'((oc >> 15) & 1)});
    pulses(1);
    check("R10 slow bit15 high", {31'd0, pin_n}, {31'd0, 1'((oc >> 15) & 1)});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule